// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block carries out one atomic memory update at a time against a single-port memory. A command supplies the operand size, a base register value with a signed 16-bit displacement, the source register value, the accumulator register value (register zero), and a 32-bit operation code. The unit locks the memory and reads the addressed location. It then forms the new value, writes it back unless a compare fails, releases the lock, and returns writeback values for the source register and register zero.

The operations are add, or, and, exclusive-or, swap and compare-and-swap. Bit 0 of the operation code asks for the old memory value to be returned to the source register. Swap and compare-and-swap are only legal with that bit set. Word (32-bit) and doubleword (64-bit) sizes are accepted. Any other size or operation code is rejected without touching memory.

Top module: `amo_unit`

## Requirements
- R1: `cmd_ready` is high only while the unit is idle. A command is taken when `cmd_valid` and `cmd_ready` are both high. Its result is shown by `rsp_valid` high for exactly one cycle, after which `cmd_ready` is high again.
- R2: `cmd_size` 2'b00 selects word and 2'b11 selects doubleword. Codes 2'b01 and 2'b10 (halfword, byte) return `rsp_illegal` and cause no memory access.
- R3: The legal `cmd_imm` values are 0x00 (add), 0x40 (or), 0x50 (and) and 0xa0 (xor), each optionally with bit 0 set, plus 0xe1 (swap) and 0xf1 (compare-and-swap). Any other value, including any nonzero bit in [31:8], returns `rsp_illegal` with both writeback enables low and causes no memory access.
- R4: The memory address is `cmd_base` plus `cmd_offset` sign-extended, truncated to the address width.
- R5: Add, or, and and xor store the operation of the old memory value with `cmd_src`. For word size the result wraps within 32 bits, and `mem_wdata[63:32]` is zero.
- R6: With bit 0 of `cmd_imm` set on add/or/and/xor, `rsp_src_we` is high and `rsp_src_data` is the old memory value, zero-extended for word size. Without it, neither writeback enable is raised.
- R7: Swap (0xe1) stores `cmd_src` (low 32 bits for word) and returns the old memory value on `rsp_src_data` with `rsp_src_we` high.
- R8: Compare-and-swap (0xf1) stores `cmd_src` only when the old memory value equals `cmd_r0`, compared at the operand width. Otherwise it makes no write. In both cases `rsp_r0_we` is high with the zero-extended old value, and `rsp_src_we` is low.
- R9: `mem_lock` is high on every cycle from the read request until the write is granted (or the read data arrives, when the compare fails). Every `mem_req` cycle has `mem_lock` high, and `mem_lock` is low while `rsp_valid` is high.
- R10: Each legal command makes exactly one read and then at most one write. A request holds its address and direction until `mem_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_size | input | 2 | Size code: 00 word, 11 doubleword |
| cmd_imm | input | 32 | Operation code with fetch bit 0 |
| cmd_base | input | 64 | Base register value |
| cmd_offset | input | 16 | Signed displacement |
| cmd_src | input | 64 | Source register value |
| cmd_r0 | input | 64 | Register zero value (compare operand) |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory accepts request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_dword | output | 1 | Request is 64-bit (else 32-bit in low lane) |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data (word in low 32 bits) |
| mem_lock | output | 1 | Location locked for the read-modify-write |
| rsp_valid | output | 1 | Result pulse |
| rsp_illegal | output | 1 | Command rejected |
| rsp_src_we | output | 1 | Write `rsp_src_data` to source register |
| rsp_src_data | output | 64 | Old memory value for source register |
| rsp_r0_we | output | 1 | Write `rsp_r0_data` to register zero |
| rsp_r0_data | output | 64 | Old memory value for register zero |

## Verification
Suppose the sequencer's state register were wrong, for example if it skipped the write or wrote after a failed compare. Then the bench's memory image would differ from its shadow copy, and the per-command access count would be off. Both show in the same `rsp_valid` cycle that ends that command. A wrong latched operand, size flag or address would show as a wrong fetched value, a wrong stored value, or a grant at an unexpected address. The address check runs on every granted request, and the other two checks run at that command's response pulse. Suppose the lock flag were ever dropped while a request is up. Then a per-cycle lock watch counts it on the cycle it happens.

// File: rtl/amo_pkg.sv
package amo_pkg;

   // size field codes (bits [4:3] of the opcode)
   localparam logic [1:0] SZ_WORD  = 2'b00;
   localparam logic [1:0] SZ_DWORD = 2'b11;

   // operation codes carried in the low byte of the immediate
   localparam logic [7:0] IMM_ADD  = 8'h00;
   localparam logic [7:0] IMM_OR   = 8'h40;
   localparam logic [7:0] IMM_AND  = 8'h50;
   localparam logic [7:0] IMM_XOR  = 8'ha0;
   localparam logic [7:0] IMM_SWAP = 8'he1;
   localparam logic [7:0] IMM_CAS  = 8'hf1;

   typedef enum logic [2:0] {
      OP_ADD,
      OP_OR,
      OP_AND,
      OP_XOR,
      OP_SWAP,
      OP_CAS
   } amo_op_e;

   typedef struct packed {
      amo_op_e op;
      logic    fetch;
      logic    dword;
      logic    legal;
   } amo_dec_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WAIT,
      ST_CALC,
      ST_WR,
      ST_DONE
   } amo_state_e;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
   import amo_pkg::*;
#(
   parameter int IMM_W = 32
) (
   input  logic [1:0]       size,
   input  logic [IMM_W-1:0] imm,
   output amo_dec_t         dec
);

   localparam int CODE_W = 8;

   if (IMM_W <= CODE_W) begin : g_bad_imm
      $error("amo_decode: IMM_W must exceed the 8-bit operation code");
   end

   logic            code_ok;
   logic            size_ok;
   logic            high_zero;
   amo_op_e         op;

   assign high_zero = (imm[IMM_W-1:CODE_W] == '0);
   assign size_ok   = (size == SZ_WORD) || (size == SZ_DWORD);

   always_comb begin
      code_ok = 1'b1;
      op      = OP_ADD;
      unique case (imm[CODE_W-1:0])
         IMM_ADD, IMM_ADD | 8'h01: op = OP_ADD;
         IMM_OR,  IMM_OR  | 8'h01: op = OP_OR;
         IMM_AND, IMM_AND | 8'h01: op = OP_AND;
         IMM_XOR, IMM_XOR | 8'h01: op = OP_XOR;
         IMM_SWAP:                 op = OP_SWAP;
         IMM_CAS:                  op = OP_CAS;
         default:                  code_ok = 1'b0;
      endcase
   end

   always_comb begin
      dec.op    = op;
      dec.fetch = imm[0];
      dec.dword = (size == SZ_DWORD);
      dec.legal = code_ok && size_ok && high_zero;
   end

endmodule

// File: rtl/amo_agu.sv
module amo_agu #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 64,
   parameter int OFF_W  = 16
) (
   input  logic [DATA_W-1:0] base,
   input  logic [OFF_W-1:0]  offset,
   output logic [ADDR_W-1:0] addr
);

   if (ADDR_W > DATA_W || ADDR_W < OFF_W) begin : g_bad_addr
      $error("amo_agu: need OFF_W <= ADDR_W <= DATA_W");
   end

   logic [ADDR_W-1:0] disp;

   // displacement widening picks a variant on the width relation
   if (ADDR_W == OFF_W) begin : g_same
      assign disp = offset;
   end else begin : g_sext
      assign disp = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
   end

   assign addr = base[ADDR_W-1:0] + disp;

endmodule

// File: rtl/amo_alu.sv
module amo_alu
   import amo_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 32
) (
   input  amo_op_e           op,
   input  logic              dword,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] src_val,
   input  logic [DATA_W-1:0] cmp_val,
   output logic [DATA_W-1:0] new_val,
   output logic              do_write
);

   localparam int LANES = DATA_W / LANE_W;

   if (LANES * LANE_W != DATA_W || LANES < 2) begin : g_bad_lane
      $error("amo_alu: DATA_W must be a multiple (>=2) of LANE_W");
   end

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] raw;

   // lane 0 always live, upper lanes only for full-width operations
   for (genvar l = 0; l < LANES; l++) begin : g_mask
      if (l == 0) begin : g_low
         assign mask[LANE_W-1:0] = '1;
      end else begin : g_up
         assign mask[l*LANE_W +: LANE_W] = {LANE_W{dword}};
      end
   end

   always_comb begin
      unique case (op)
         OP_ADD:  raw = old_val + src_val;
         OP_OR:   raw = old_val | src_val;
         OP_AND:  raw = old_val & src_val;
         OP_XOR:  raw = old_val ^ src_val;
         default: raw = src_val;
      endcase
   end

   assign new_val  = raw & mask;
   assign do_write = (op != OP_CAS) || ((old_val & mask) == (cmp_val & mask));

endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
   import amo_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  amo_dec_t          dec_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] src_in,
   input  logic [DATA_W-1:0] r0_in,
   output amo_dec_t          dec_q,
   output logic [DATA_W-1:0] old_q,
   output logic [DATA_W-1:0] src_q,
   output logic [DATA_W-1:0] r0_q,
   input  logic [DATA_W-1:0] alu_new,
   input  logic              alu_wr,
   output logic              mem_req,
   input  logic              mem_gnt,
   output logic              mem_we,
   output logic              mem_dword,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_lock,
   output logic              rsp_valid,
   output logic              rsp_illegal,
   output logic              rsp_src_we,
   output logic [DATA_W-1:0] rsp_src_data,
   output logic              rsp_r0_we,
   output logic [DATA_W-1:0] rsp_r0_data
);

   localparam int HALF_W = DATA_W / 2;

   amo_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] new_q;
   logic              bad_q;
   logic              fire;

   assign fire = cmd_valid && (state == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         dec_q  <= '0;
         addr_q <= '0;
         src_q  <= '0;
         r0_q   <= '0;
         old_q  <= '0;
         new_q  <= '0;
         bad_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (cmd_valid) begin
               dec_q  <= dec_in;
               addr_q <= addr_in;
               src_q  <= src_in;
               r0_q   <= r0_in;
               old_q  <= '0;
               bad_q  <= !dec_in.legal;
               state  <= dec_in.legal ? ST_RD : ST_DONE;
            end
            ST_RD:   if (mem_gnt) state <= ST_WAIT;
            ST_WAIT: if (mem_rvalid) begin
               old_q <= dec_q.dword ? mem_rdata : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
               state <= ST_CALC;
            end
            ST_CALC: begin
               new_q <= alu_new;
               state <= alu_wr ? ST_WR : ST_DONE;
            end
            ST_WR:   if (mem_gnt) state <= ST_DONE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cmd_ready = (state == ST_IDLE);
   assign mem_req   = (state == ST_RD) || (state == ST_WR);
   assign mem_we    = (state == ST_WR);
   assign mem_dword = dec_q.dword;
   assign mem_addr  = addr_q;
   assign mem_wdata = new_q;
   assign mem_lock  = (state == ST_RD) || (state == ST_WAIT) ||
                      (state == ST_CALC) || (state == ST_WR);

   assign rsp_valid    = (state == ST_DONE);
   assign rsp_illegal  = rsp_valid && bad_q;
   assign rsp_src_we   = rsp_valid && !bad_q &&
                         ((dec_q.op == OP_SWAP) || (dec_q.fetch && dec_q.op != OP_CAS));
   assign rsp_r0_we    = rsp_valid && !bad_q && (dec_q.op == OP_CAS);
   assign rsp_src_data = old_q;
   assign rsp_r0_data  = old_q;

   // R1: one-cycle response, unit idle afterwards
   a_r1_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && cmd_ready));

   // R3: rejected command goes straight to a response with no request
   a_r3_reject_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !dec_in.legal) |=> (rsp_illegal && !mem_req));

   // R9: every request is made under the lock
   a_r9_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_lock);

   // R9: lock released by the time the result is shown
   a_r9_unlock_at_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !mem_lock);

   // R10: a pending request keeps address and direction
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R6: word fetch returns a zero upper half
   a_r6_word_zext: assert property (@(posedge clk) disable iff (!rst_n)
      ((rsp_src_we || rsp_r0_we) && !mem_dword) |-> (rsp_src_data[DATA_W-1:HALF_W] == '0));

   // R5: word writes carry nothing in the upper half
   a_r5_word_wdata: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !mem_dword) |-> (mem_wdata[DATA_W-1:HALF_W] == '0));

endmodule

// File: rtl/amo_unit.sv
module amo_unit
   import amo_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 64,
   parameter int OFF_W  = 16,
   parameter int IMM_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_size,
   input  logic [IMM_W-1:0]  cmd_imm,
   input  logic [DATA_W-1:0] cmd_base,
   input  logic [OFF_W-1:0]  cmd_offset,
   input  logic [DATA_W-1:0] cmd_src,
   input  logic [DATA_W-1:0] cmd_r0,
   output logic              mem_req,
   input  logic              mem_gnt,
   output logic              mem_we,
   output logic              mem_dword,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_lock,
   output logic              rsp_valid,
   output logic              rsp_illegal,
   output logic              rsp_src_we,
   output logic [DATA_W-1:0] rsp_src_data,
   output logic              rsp_r0_we,
   output logic [DATA_W-1:0] rsp_r0_data
);

   localparam int LANE_W = DATA_W / 2;

   if (DATA_W != 64) begin : g_bad_data
      $error("amo_unit: word/doubleword operation needs DATA_W of 64");
   end

   amo_dec_t          dec_in;
   amo_dec_t          dec_q;
   logic [ADDR_W-1:0] addr_in;
   logic [DATA_W-1:0] old_q;
   logic [DATA_W-1:0] src_q;
   logic [DATA_W-1:0] r0_q;
   logic [DATA_W-1:0] alu_new;
   logic              alu_wr;

   amo_decode #(.IMM_W(IMM_W)) u_dec (
      .size (cmd_size),
      .imm  (cmd_imm),
      .dec  (dec_in)
   );

   amo_agu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agu (
      .base   (cmd_base),
      .offset (cmd_offset),
      .addr   (addr_in)
   );

   amo_alu #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_alu (
      .op       (dec_q.op),
      .dword    (dec_q.dword),
      .old_val  (old_q),
      .src_val  (src_q),
      .cmp_val  (r0_q),
      .new_val  (alu_new),
      .do_write (alu_wr)
   );

   amo_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_ready    (cmd_ready),
      .dec_in       (dec_in),
      .addr_in      (addr_in),
      .src_in       (cmd_src),
      .r0_in        (cmd_r0),
      .dec_q        (dec_q),
      .old_q        (old_q),
      .src_q        (src_q),
      .r0_q         (r0_q),
      .alu_new      (alu_new),
      .alu_wr       (alu_wr),
      .mem_req      (mem_req),
      .mem_gnt      (mem_gnt),
      .mem_we       (mem_we),
      .mem_dword    (mem_dword),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .mem_rvalid   (mem_rvalid),
      .mem_rdata    (mem_rdata),
      .mem_lock     (mem_lock),
      .rsp_valid    (rsp_valid),
      .rsp_illegal  (rsp_illegal),
      .rsp_src_we   (rsp_src_we),
      .rsp_src_data (rsp_src_data),
      .rsp_r0_we    (rsp_r0_we),
      .rsp_r0_data  (rsp_r0_data)
   );

endmodule

// File: tb/tb_amo_unit.sv
module tb_amo_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_size = 2'b00;
   logic [31:0] cmd_imm = '0;
   logic [63:0] cmd_base = '0;
   logic [15:0] cmd_offset = '0;
   logic [63:0] cmd_src = '0;
   logic [63:0] cmd_r0 = '0;
   logic        mem_req, mem_gnt, mem_we, mem_dword, mem_lock;
   logic [63:0] mem_addr, mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        rsp_valid, rsp_illegal, rsp_src_we, rsp_r0_we;
   logic [63:0] rsp_src_data, rsp_r0_data;

   always #2 clk = ~clk;

   amo_unit dut (.*);

   int total = 0;
   int bad = 0;
   int acc_total = 0;
   int lock_viol = 0;

   logic [63:0] mem [16];
   logic [63:0] ref_mem [16];
   logic [1:0]  gcnt = 2'd0;

   assign mem_gnt = mem_req && (gcnt != 2'd0);

   always @(posedge clk) begin
      gcnt       <= rst_n ? gcnt + 2'd1 : 2'd0;
      mem_rvalid <= 1'b0;
      if (rst_n && mem_req && mem_gnt) begin
         acc_total <= acc_total + 1;
         if (mem_we) begin
            if (mem_dword) mem[mem_addr[6:3]] <= mem_wdata;
            else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
            else mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
         end else begin
            mem_rvalid <= 1'b1;
            if (mem_dword) mem_rdata <= mem[mem_addr[6:3]];
            else mem_rdata <= {32'h0, mem_addr[2] ? mem[mem_addr[6:3]][63:32]
                                                   : mem[mem_addr[6:3]][31:0]};
         end
      end
   end

   typedef struct {
      string       name;
      logic        illegal;
      logic        src_we;
      logic [63:0] src_d;
      logic        r0_we;
      logic [63:0] r0_d;
      logic [63:0] addr;
      logic [63:0] mem_after;
      int          acc_base;
      int          acc_exp;
   } exp_t;

   exp_t exp_q[$];

   task automatic chk(input bit ok, input string req, input string name,
                      input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, name, act, expv);
      end
   endtask

   // driver: computes the expected item from the shadow memory, then drives
   task automatic issue(input string name, input logic [1:0] size, input logic [31:0] imm,
                        input logic [63:0] base, input logic [15:0] off,
                        input logic [63:0] src, input logic [63:0] r0);
      exp_t e;
      logic [63:0] ea, mask, old, nv;
      logic dw, legal, okimm, wr, eq;
      int idx;
      ea  = base + {{48{off[15]}}, off};
      idx = int'(ea[6:3]);
      dw  = (size == 2'b11);
      mask = dw ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
      old = dw ? ref_mem[idx] : {32'h0, ea[2] ? ref_mem[idx][63:32] : ref_mem[idx][31:0]};
      okimm = (imm[31:8] == 0) &&
              (imm[7:1] == 7'h00 || imm[7:1] == 7'h20 || imm[7:1] == 7'h28 ||
               imm[7:1] == 7'h50 || imm[7:0] == 8'he1 || imm[7:0] == 8'hf1);
      legal = okimm && (size == 2'b00 || size == 2'b11);
      eq  = ((old & mask) == (r0 & mask));
      case (imm[7:0] & 8'hFE)
         8'h00:   nv = (old + src) & mask;
         8'h40:   nv = (old | src) & mask;
         8'h50:   nv = (old & src) & mask;
         8'ha0:   nv = (old ^ src) & mask;
         default: nv = src & mask;
      endcase
      wr = legal && !(imm[7:0] == 8'hf1 && !eq);
      if (wr) begin
         if (dw) ref_mem[idx] = nv;
         else if (ea[2]) ref_mem[idx][63:32] = nv[31:0];
         else ref_mem[idx][31:0] = nv[31:0];
      end
      e.name      = name;
      e.illegal   = !legal;
      e.src_we    = legal && imm[0] && imm[7:0] != 8'hf1;
      e.src_d     = old;
      e.r0_we     = legal && imm[7:0] == 8'hf1;
      e.r0_d      = old;
      e.addr      = ea;
      e.mem_after = ref_mem[idx];
      e.acc_base  = acc_total;
      e.acc_exp   = !legal ? 0 : (wr ? 2 : 1);
      exp_q.push_back(e);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_size = size; cmd_imm = imm; cmd_base = base;
      cmd_offset = off; cmd_src = src; cmd_r0 = r0;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   // monitor: address on each grant, lock each cycle, results on the pulse
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && !mem_lock) lock_viol++;
         if (mem_req && mem_gnt && exp_q.size() != 0)
            chk(mem_addr == exp_q[0].addr, "R4", {exp_q[0].name, " addr"}, mem_addr, exp_q[0].addr);
         if (rsp_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected rsp", 64'h1, 64'h0);
            else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(rsp_illegal == e.illegal, "R2/R3", {e.name, " illegal"}, 64'(rsp_illegal), 64'(e.illegal));
               chk(rsp_src_we == e.src_we, "R6/R7", {e.name, " src_we"}, 64'(rsp_src_we), 64'(e.src_we));
               chk(rsp_r0_we == e.r0_we, "R8", {e.name, " r0_we"}, 64'(rsp_r0_we), 64'(e.r0_we));
               if (e.src_we) chk(rsp_src_data == e.src_d, "R6/R7", {e.name, " src_data"}, rsp_src_data, e.src_d);
               if (e.r0_we)  chk(rsp_r0_data == e.r0_d, "R8", {e.name, " r0_data"}, rsp_r0_data, e.r0_d);
               chk(mem[e.addr[6:3]] == e.mem_after, "R5/R7/R8", {e.name, " memory"},
                   mem[e.addr[6:3]], e.mem_after);
               chk(acc_total - e.acc_base == e.acc_exp, "R10", {e.name, " access count"},
                   64'(acc_total - e.acc_base), 64'(e.acc_exp));
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem[i]     = {32'hA000_0000 | 32'(i), 32'h1000_0000 + 32'(i * 3)};
         ref_mem[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R1", "reset ready", 64'(cmd_ready), 64'h1);
      chk(rsp_valid == 1'b0, "R1", "reset rsp", 64'(rsp_valid), 64'h0);
      chk(mem_req == 1'b0 && mem_lock == 1'b0, "R9", "reset mem idle", 64'({mem_req, mem_lock}), 64'h0);

      // R5 simple ops, R6 fetch bit
      issue("r5_add_dw",        2'b11, 32'h00, 64'h0,  16'h0008, 64'h5, 64'h0);
      issue("r7_swap_word",     2'b00, 32'he1, 64'h10, 16'h0000, 64'h1234_5678_FFFF_FFFF, 64'h0);
      issue("r5_add_word_wrap", 2'b00, 32'h01, 64'h10, 16'h0000, 64'hDEAD_0000_0000_0003, 64'h0);
      issue("r6_or_fetch_dw",   2'b11, 32'h41, 64'h20, 16'h0000, 64'h00F0_0000_0000_0F00, 64'h0);
      issue("r5_and_word_hi",   2'b00, 32'h50, 64'h18, 16'h0004, 64'hFFFF_FFFF_0000_FFFF, 64'h0);
      issue("r4_xor_neg_off",   2'b11, 32'ha1, 64'h40, 16'hFFF8, 64'h5555_AAAA_5555_AAAA, 64'h0);
      issue("r6_and_fetch_dw",  2'b11, 32'h51, 64'h28, 16'h0000, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0);
      issue("r7_swap_dw",       2'b11, 32'he1, 64'h30, 16'h0000, 64'hCAFE_F00D_0123_4567, 64'h0);
      // R8 compare-and-swap hit, miss, word-width compare
      issue("r8_cas_hit_dw",    2'b11, 32'hf1, 64'h48, 16'h0000, 64'h1111_2222_3333_4444, ref_mem[9]);
      issue("r8_cas_miss_dw",   2'b11, 32'hf1, 64'h50, 16'h0000, 64'h9999, ref_mem[10] ^ 64'h1);
      issue("r8_cas_hit_word",  2'b00, 32'hf1, 64'h58, 16'h0000, 64'h7777_8888,
            {32'hFFFF_FFFF, ref_mem[11][31:0]});
      // R2 size rejects, R3 code rejects
      issue("r2_half",          2'b01, 32'h00, 64'h60, 16'h0000, 64'h1, 64'h0);
      issue("r2_byte",          2'b10, 32'h01, 64'h60, 16'h0000, 64'h1, 64'h0);
      issue("r3_bad_code",      2'b11, 32'h02, 64'h60, 16'h0000, 64'h1, 64'h0);
      issue("r3_swap_nofetch",  2'b11, 32'he0, 64'h60, 16'h0000, 64'h1, 64'h0);
      issue("r3_high_bits",     2'b11, 32'h100, 64'h60, 16'h0000, 64'h1, 64'h0);
      issue("r1_after_reject",  2'b00, 32'h01, 64'h60, 16'h0004, 64'h10, 64'h0);

      chk(lock_viol == 0, "R9", "request without lock", 64'(lock_viol), 64'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule